// File: doc/BRIEF.md
# Floating-Point Comparator with Condition Flags

This block compares two IEEE 754 operands and reports the relation between them as four condition flags (negative, zero, carry, overflow) plus an invalid-operation exception bit. A precision select chooses between single and double precision. In single precision only the low 32 bits of each 64-bit operand bus are used. One mode bit replaces the second operand with positive zero. Another mode bit decides whether quiet NaNs raise the exception or only signalling NaNs do. A flush-to-zero control makes subnormal inputs count as positive zero.

The comparison itself is combinational. Its result is captured in an output register when `inValid` is high, so `outValid` and the flags appear one clock later. Between results the flags hold their last value. A pipeline can issue one compare per cycle and take the flags into its own condition state.

Top module: `fcmp_nzcv`

## Requirements
- R1: When the first operand is less than the second, the flags {N,Z,C,V} are 4'b1000.
- R2: When the operands are equal, the flags are 4'b0110.
- R3: When the first operand is greater than the second, the flags are 4'b0010.
- R4: When either operand is a NaN, the result is unordered and the flags are 4'b0011. Two NaNs with identical bit patterns are also unordered.
- R5: +0 and -0 compare equal. Infinities of the same sign compare equal. -inf is below every number and below +inf. +inf is above every number.
- R6: With `quietSignals`=0, `invalidOp` is 1 only when an operand is a signalling NaN. A signalling NaN has an all-ones exponent, fraction MSB 0 and a nonzero fraction. A quiet NaN has an all-ones exponent and fraction MSB 1. A quiet NaN gives an unordered result with `invalidOp`=0.
- R7: With `quietSignals`=1, any NaN operand, quiet or signalling, sets `invalidOp`.
- R8: A compare in which neither operand is a NaN never sets `invalidOp`.
- R9: With `flushZero`=1, a subnormal operand (exponent 0, nonzero fraction) of either sign compares as +0. With `flushZero`=0, subnormals are ordered by their value.
- R10: With `cmpZero`=1, the first operand is compared against +0 and `opB` has no effect.
- R11: With `isDouble`=0, only bits [31:0] of each operand are used and bits [63:32] have no effect. With `isDouble`=1, all 64 bits form a double-precision value.
- R12: A result appears with `outValid`=1 in the cycle after `inValid`=1 is sampled. When no input is sampled, `outValid` is 0 and the flags and `invalidOp` keep their previous values.
- R13: While `rstN` is low, `outValid`, all four flags and `invalidOp` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operands and mode bits are valid this cycle |
| isDouble | input | 1 | 1 selects double precision, 0 selects single |
| cmpZero | input | 1 | Compare the first operand against +0 |
| quietSignals | input | 1 | Quiet NaNs also raise invalid-operation |
| flushZero | input | 1 | Treat subnormal operands as +0 |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| outValid | output | 1 | Result registered from the previous cycle |
| flagN | output | 1 | Less-than flag |
| flagZ | output | 1 | Equal flag |
| flagC | output | 1 | Equal, greater or unordered flag |
| flagV | output | 1 | Unordered flag |
| invalidOp | output | 1 | Invalid-operation exception |

## Verification
Each result is due exactly one rising edge after its operands are sampled. The bench drives inputs on the falling edge and reads the outputs on the next falling edge. That read point is half a cycle after the register that holds the result has loaded. Back-to-back vectors keep the same one-edge spacing, so every read sees only the vector issued just before it. For the hold check, the bench changes the operands with `inValid` low. It then reads the outputs one falling edge later and expects the old flags with `outValid` at 0.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  localparam int SP_EXP  = 8;
  localparam int SP_FRAC = 23;
  localparam int DP_EXP  = 11;
  localparam int DP_FRAC = 52;
  localparam int SP_W    = 1 + SP_EXP + SP_FRAC;
  localparam int DP_W    = 1 + DP_EXP + DP_FRAC;
  localparam int MAG_W   = DP_EXP + DP_FRAC;
  localparam int NUM_OPS = 2;

  // Classified operand: magnitude is zero-extended to the double width.
  typedef struct packed {
    logic             isNan;
    logic             isSnan;
    logic             isZero;
    logic             sign;
    logic [MAG_W-1:0] mag;
  } opInfo_t;

  // Strobes from control to datapath.
  typedef struct packed {
    logic capture;
    logic useDouble;
    logic zeroB;
    logic trapQuiet;
    logic flush;
  } cmpStrobe_t;

  typedef enum logic [1:0] {
    OUT_LT = 2'd0,
    OUT_EQ = 2'd1,
    OUT_GT = 2'd2,
    OUT_UN = 2'd3
  } cmpOutcome_t;

endpackage

// File: rtl/fcmp_classify.sv
module fcmp_classify
  import fcmp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
  input  logic [WORD_W-1:0] word,
  input  logic              flush,
  output opInfo_t           info
);

  logic [EXP_W-1:0]  expField;
  logic [FRAC_W-1:0] fracField;
  logic              expAllOnes;
  logic              expAllZero;
  logic              fracNonZero;
  logic              zeroLike;
  logic [MAG_W-1:0]  magExt;

  always_comb begin
    expField    = word[FRAC_W +: EXP_W];
    fracField   = word[FRAC_W-1:0];
    expAllOnes  = &expField;
    expAllZero  = ~|expField;
    fracNonZero = |fracField;

    // A true zero, or a subnormal when flushing.
    zeroLike = expAllZero & (~fracNonZero | flush);

    magExt = '0;
    magExt[EXP_W+FRAC_W-1:0] = {expField, fracField};

    info.isNan  = expAllOnes & fracNonZero;
    info.isSnan = expAllOnes & fracNonZero & ~fracField[FRAC_W-1];
    info.isZero = zeroLike;
    // Zeros carry a positive sign so that +0 and -0 meet in one code.
    info.sign   = word[WORD_W-1] & ~zeroLike;
    info.mag    = zeroLike ? '0 : magExt;
  end

endmodule

// File: rtl/fcmp_ctrl.sv
module fcmp_ctrl
  import fcmp_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic       isDouble,
  input  logic       cmpZero,
  input  logic       quietSignals,
  input  logic       flushZero,
  output cmpStrobe_t strobe,
  output logic       outValid
);

  always_comb begin
    strobe.capture   = inValid;
    strobe.useDouble = isDouble;
    strobe.zeroB     = cmpZero;
    strobe.trapQuiet = quietSignals;
    strobe.flush     = flushZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) outValid <= 1'b0;
    else       outValid <= inValid;
  end

endmodule

// File: rtl/fcmp_datapath.sv
module fcmp_datapath
  import fcmp_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  cmpStrobe_t      strobe,
  input  logic [DP_W-1:0] opA,
  input  logic [DP_W-1:0] opB,
  output logic            flagN,
  output logic            flagZ,
  output logic            flagC,
  output logic            flagV,
  output logic            invalidOp
);

  logic [DP_W-1:0] opWord [NUM_OPS];
  opInfo_t         spInfo [NUM_OPS];
  opInfo_t         dpInfo [NUM_OPS];
  opInfo_t         selInfo[NUM_OPS];

  assign opWord[0] = opA;
  assign opWord[1] = strobe.zeroB ? '0 : opB;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    fcmp_classify #(.EXP_W(SP_EXP), .FRAC_W(SP_FRAC)) u_sp (
      .word  (opWord[g][SP_W-1:0]),
      .flush (strobe.flush),
      .info  (spInfo[g])
    );
    fcmp_classify #(.EXP_W(DP_EXP), .FRAC_W(DP_FRAC)) u_dp (
      .word  (opWord[g]),
      .flush (strobe.flush),
      .info  (dpInfo[g])
    );
    assign selInfo[g] = strobe.useDouble ? dpInfo[g] : spInfo[g];
  end

  cmpOutcome_t outcome;
  logic        trapNow;
  logic        magLess;
  logic        magSame;
  logic        anyNan;

  always_comb begin
    anyNan  = selInfo[0].isNan | selInfo[1].isNan;
    magLess = selInfo[0].mag < selInfo[1].mag;
    magSame = selInfo[0].mag == selInfo[1].mag;
    trapNow = (selInfo[0].isNan & (selInfo[0].isSnan | strobe.trapQuiet)) |
              (selInfo[1].isNan & (selInfo[1].isSnan | strobe.trapQuiet));

    if (anyNan)
      outcome = OUT_UN;
    else if (selInfo[0].sign != selInfo[1].sign)
      outcome = selInfo[0].sign ? OUT_LT : OUT_GT;
    else if (magSame)
      outcome = OUT_EQ;
    else if (magLess ^ selInfo[0].sign)
      outcome = OUT_LT;
    else
      outcome = OUT_GT;
  end

  logic [3:0] nzcvNext;

  always_comb begin
    unique case (outcome)
      OUT_LT:  nzcvNext = 4'b1000;
      OUT_EQ:  nzcvNext = 4'b0110;
      OUT_GT:  nzcvNext = 4'b0010;
      default: nzcvNext = 4'b0011;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {flagN, flagZ, flagC, flagV} <= 4'b0000;
      invalidOp                    <= 1'b0;
    end else if (strobe.capture) begin
      {flagN, flagZ, flagC, flagV} <= nzcvNext;
      invalidOp                    <= trapNow;
    end
  end

endmodule

// File: rtl/fcmp_nzcv.sv
module fcmp_nzcv
  import fcmp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic        isDouble,
  input  logic        cmpZero,
  input  logic        quietSignals,
  input  logic        flushZero,
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  output logic        outValid,
  output logic        flagN,
  output logic        flagZ,
  output logic        flagC,
  output logic        flagV,
  output logic        invalidOp
);

  cmpStrobe_t strobe;

  fcmp_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .isDouble     (isDouble),
    .cmpZero      (cmpZero),
    .quietSignals (quietSignals),
    .flushZero    (flushZero),
    .strobe       (strobe),
    .outValid     (outValid)
  );

  fcmp_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .opA       (opA),
    .opB       (opB),
    .flagN     (flagN),
    .flagZ     (flagZ),
    .flagC     (flagC),
    .flagV     (flagV),
    .invalidOp (invalidOp)
  );

endmodule

// File: rtl/fcmp_nzcv_chk.sv
module fcmp_nzcv_chk (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic quietSignals,
  input logic outValid,
  input logic flagN,
  input logic flagZ,
  input logic flagC,
  input logic flagV,
  input logic invalidOp
);

  AST_FLAGS_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ({flagN, flagZ, flagC, flagV} inside {4'b1000, 4'b0110, 4'b0010, 4'b0011})); // R4

  AST_INVALID_NEEDS_NAN: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && invalidOp) |-> flagV); // R8

  AST_QUIET_TRAPS: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && flagV && $past(quietSignals)) |-> invalidOp); // R7

  AST_RESULT_DUE: assert property (@(posedge clk) disable iff (!rstN)
    $past(inValid) |-> outValid); // R12

  AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid) |-> !outValid); // R12

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable({flagN, flagZ, flagC, flagV, invalidOp})); // R12

endmodule

bind fcmp_nzcv fcmp_nzcv_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .inValid      (inValid),
  .quietSignals (quietSignals),
  .outValid     (outValid),
  .flagN        (flagN),
  .flagZ        (flagZ),
  .flagC        (flagC),
  .flagV        (flagV),
  .invalidOp    (invalidOp)
);

// File: tb/fcmp_nzcv_tb.sv
module fcmp_nzcv_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        isDouble = 1'b0;
  logic        cmpZero = 1'b0;
  logic        quietSignals = 1'b0;
  logic        flushZero = 1'b0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        outValid, flagN, flagZ, flagC, flagV, invalidOp;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fcmp_nzcv u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .isDouble(isDouble),
    .cmpZero(cmpZero), .quietSignals(quietSignals), .flushZero(flushZero),
    .opA(opA), .opB(opB), .outValid(outValid), .flagN(flagN), .flagZ(flagZ),
    .flagC(flagC), .flagV(flagV), .invalidOp(invalidOp)
  );

  // Reference: fields to a signed integer key, NaNs flagged apart.
  function automatic void refField(input logic [63:0] w, input logic dbl, input logic fz,
                                   output longint key, output logic nan, output logic snan);
    logic   s;
    longint e, f, eMax, fBits, mag;
    if (dbl) begin
      s = w[63]; e = longint'(w[62:52]); f = longint'(w[51:0]); eMax = 2047; fBits = 52;
    end else begin
      s = w[31]; e = longint'(w[30:23]); f = longint'(w[22:0]); eMax = 255; fBits = 23;
    end
    nan  = (e == eMax) && (f != 0);
    snan = nan && (((f >> (fBits - 1)) & 1) == 0);
    if (e == 0 && fz) f = 0;
    mag = (e << fBits) | f;
    key = s ? -mag : mag;
  endfunction

  function automatic logic [4:0] refModel(input logic [63:0] a, input logic [63:0] b,
                                          input logic dbl, input logic zr,
                                          input logic sq, input logic fz);
    longint ka, kb;
    logic na, nb, sa, sb, inv;
    refField(a, dbl, fz, ka, na, sa);
    refField(zr ? 64'd0 : b, dbl, fz, kb, nb, sb);
    inv = (na && (sa || sq)) || (nb && (sb || sq));
    if (na || nb)   return {4'b0011, inv};
    if (ka < kb)    return {4'b1000, inv};
    if (ka == kb)   return {4'b0110, inv};
    return {4'b0010, inv};
  endfunction

  logic [4:0] lastExp;

  task automatic report(input string tag, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got v/nzcv/inv=%b expected %b (a=%h b=%h d=%b z=%b q=%b f=%b)",
               tag, act, exp, opA, opB, isDouble, cmpZero, quietSignals, flushZero);
    end
  endtask

  task automatic applyVec(input string tag, input logic [63:0] a, input logic [63:0] b,
                          input logic dbl, input logic zr, input logic sq, input logic fz);
    logic [4:0] e;
    opA = a; opB = b; isDouble = dbl; cmpZero = zr; quietSignals = sq; flushZero = fz;
    inValid = 1'b1;
    e = refModel(a, b, dbl, zr, sq, fz);
    @(negedge clk);
    lastExp = e;
    report(tag, {outValid, flagN, flagZ, flagC, flagV, invalidOp}, {1'b1, e});
  endtask

  function automatic string outcomeTag(input logic [4:0] e);
    case (e[4:1])
      4'b1000: return "R1";
      4'b0110: return "R2";
      4'b0010: return "R3";
      default: return "R4";
    endcase
  endfunction

  function automatic logic [63:0] genOperand(input logic dbl);
    logic [63:0] w;
    logic        s;
    int          kind;
    w = {$urandom, $urandom};
    s = w[63];
    kind = $urandom % 8;
    if (dbl) begin
      case (kind)
        0: w = {s, 63'd0};
        1: w = {s, 11'h7ff, 52'd0};
        2: w[62:51] = 12'hfff;
        3: begin w[62:51] = 12'hffe; w[0] = 1'b1; end
        4: begin w[62:52] = 11'd0; w[0] = 1'b1; end
        default: if (&w[62:52]) w[62] = 1'b0;
      endcase
    end else begin
      case (kind)
        0: w[31:0] = {s, 31'd0};
        1: w[31:0] = {s, 8'hff, 23'd0};
        2: w[30:22] = 9'h1ff;
        3: begin w[30:22] = 9'h1fe; w[0] = 1'b1; end
        4: begin w[30:23] = 8'd0; w[0] = 1'b1; end
        default: if (&w[30:23]) w[30] = 1'b0;
      endcase
    end
    return w;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [63:0] a, b;
    logic [4:0]  held;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    // R13: reset state
    report("R13", {outValid, flagN, flagZ, flagC, flagV, invalidOp}, 6'b0);
    rstN = 1'b1;
    @(negedge clk);

    // Single precision: 1.0=3f800000 2.0=40000000 -1.0=bf800000 -2.0=c0000000
    applyVec("R1", 64'h3f800000, 64'h40000000, 0, 0, 0, 0);
    applyVec("R1", 64'hc0000000, 64'hbf800000, 0, 0, 0, 0);
    applyVec("R2", 64'h3f800000, 64'h3f800000, 0, 0, 0, 0);
    applyVec("R3", 64'h40000000, 64'h3f800000, 0, 0, 0, 0);
    applyVec("R3", 64'hbf800000, 64'hc0000000, 0, 0, 0, 0);
    applyVec("R5", 64'h00000000, 64'h80000000, 0, 0, 0, 0);
    applyVec("R5", 64'h7f800000, 64'h7f800000, 0, 0, 0, 0);
    applyVec("R5", 64'hff800000, 64'hff800000, 0, 0, 0, 0);
    applyVec("R5", 64'hff800000, 64'hc0000000, 0, 0, 0, 0);
    applyVec("R5", 64'h7f800000, 64'hff800000, 0, 0, 0, 0);
    applyVec("R4", 64'h7fc00000, 64'h7fc00000, 0, 0, 0, 0);
    applyVec("R6", 64'h7fc00001, 64'h3f800000, 0, 0, 0, 0);
    applyVec("R6", 64'h3f800000, 64'h7f800001, 0, 0, 0, 0);
    applyVec("R7", 64'h7fc00000, 64'h3f800000, 0, 0, 1, 0);
    applyVec("R7", 64'h3f800000, 64'hffc00000, 0, 0, 1, 0);
    applyVec("R8", 64'h3f800000, 64'h40000000, 0, 0, 1, 0);
    applyVec("R9", 64'h00000001, 64'h00000000, 0, 0, 0, 0);
    applyVec("R9", 64'h00000001, 64'h00000000, 0, 0, 0, 1);
    applyVec("R9", 64'h80000001, 64'h00000000, 0, 0, 0, 0);
    applyVec("R9", 64'h80000001, 64'h00000000, 0, 0, 0, 1);
    applyVec("R10", 64'hbf800000, 64'hff800000, 0, 1, 0, 0);
    applyVec("R10", 64'h80000000, 64'h7fc00000, 0, 1, 1, 0);
    applyVec("R11", 64'hffffffff_3f800000, 64'h00000000_3f800000, 0, 0, 0, 0);
    applyVec("R11", 64'h3ff00000_00000000, 64'h40000000_00000000, 1, 0, 0, 0);
    applyVec("R11", 64'h7ff80000_00000000, 64'h7ff80000_00000000, 1, 0, 0, 0);
    applyVec("R11", 64'h7ff00000_00000001, 64'h00000000_00000000, 1, 0, 0, 0);

    // R12: inputs change with inValid low, outputs hold
    held = lastExp;
    inValid = 1'b0;
    opA = 64'h3f800000; opB = 64'h40000000; isDouble = 1'b0;
    @(negedge clk);
    report("R12", {outValid, flagN, flagZ, flagC, flagV, invalidOp}, {1'b0, held});
    @(negedge clk);
    report("R12", {outValid, flagN, flagZ, flagC, flagV, invalidOp}, {1'b0, held});

    for (int i = 0; i < 4000; i++) begin
      logic       dbl, zr, sq, fz;
      logic [4:0] e;
      dbl = $urandom % 2; zr = ($urandom % 8) == 0;
      sq = $urandom % 2;  fz = $urandom % 2;
      a = genOperand(dbl);
      case ($urandom % 6)
        0: b = a;
        1: b = dbl ? {~a[63], a[62:0]} : {a[63:32], ~a[31], a[30:0]};
        default: b = genOperand(dbl);
      endcase
      e = refModel(a, b, dbl, zr, sq, fz);
      applyVec(zr ? "R10" : outcomeTag(e), a, b, dbl, zr, sq, fz);
    end

    inValid = 1'b0;
    @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule